// File: doc/BRIEF.md
# Tape Block Rewrite Scheduler

This block chooses which 512-byte tape block goes to the write head next when the read-after-write CRC check runs one block behind. The read head sits behind the write head. A block's pass or fail verdict therefore arrives only while the following block is already being recorded. The scheduler keeps at most two blocks outstanding: the older one, whose verdict it awaits, and the newer one, which was written on the assumption that the older one is good.

When the older block fails, the newer block in progress is allowed to finish. The older block is then written again, followed by the newer one again, so the tape always carries them in order. This pairwise alternation repeats until the older block verifies or its sixteenth failure is counted. A sixteenth failure raises a sticky hard error that stops scheduling until reset. When the write stream ends, the most recently written block is repeated until it verifies, so the last block of every write appears on tape at least twice.

The formatter asks for each block slot with a one-cycle request. The scheduler answers on the next cycle with a block number and a flag that marks the block as a rewrite. A fresh block answered with the flag clear is taken from the buffer.

Top module: `tape_rewrite_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, issue_vld, hard_err and proto_err are 0, retry_cnt is 0 and no block is outstanding.
- R2: A slot request with data_rdy high and fewer than two blocks outstanding produces issue_vld=1, issue_rewrite=0 and issue_blk equal to data_blk on the cycle after the request. The block becomes outstanding.
- R3: When two blocks are outstanding and no rewrite is pending, a slot request produces issue_vld=0 even with data_rdy high, and the fresh block is not taken.
- R4: A crc_fail tagged with the older outstanding block raises retry_cnt by one. The next slot reissues the older block with issue_rewrite=1, and the slot after that reissues the newer block with issue_rewrite=1.
- R5: A crc_pass tagged with the older outstanding block sets retry_cnt to 0 and retires that block. The newer block becomes the older one, and a fresh block may then be issued.
- R6: With write_end high and data_rdy low, a slot request reissues the newest outstanding block with issue_rewrite=1. When no block is outstanding, the request produces issue_vld=0.
- R7: The sixteenth failure of one block sets hard_err, which stays set until reset. While hard_err is set, no slot request produces issue_vld=1.
- R8: A verdict whose tag matches neither outstanding block, or a verdict with crc_pass and crc_fail both high, pulses proto_err for one cycle and leaves retry_cnt and the outstanding blocks unchanged.
- R9: A verdict tagged with the newer block while an older block is still outstanding is ignored. It leaves proto_err at 0 and retry_cnt unchanged.
- R10: A pending rewrite takes priority over a ready fresh block. In that case the rewrite is issued and the fresh block is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_req | input | 1 | Formatter asks for the next block to record (one-cycle pulse) |
| data_rdy | input | 1 | Next sequential block is available in the buffer |
| data_blk | input | BLK_W | Number of the next sequential block |
| write_end | input | 1 | No further fresh blocks belong to this write |
| crc_pass | input | 1 | Read-after-write check passed for block crc_tag |
| crc_fail | input | 1 | Read-after-write check failed for block crc_tag |
| crc_tag | input | BLK_W | Block number the verdict refers to |
| issue_vld | output | 1 | A block number is issued for the requested slot |
| issue_blk | output | BLK_W | Block number to record |
| issue_rewrite | output | 1 | Issued block is a repeat of an outstanding block |
| retry_cnt | output | $clog2(MAX_TRIES+1) | Failures counted against the older outstanding block |
| hard_err | output | 1 | Sticky: the retry limit was reached |
| proto_err | output | 1 | One-cycle pulse on a verdict that cannot be placed |

## Verification
The bench fails the older of two outstanding blocks, then requests slots with a fresh block ready. This checks that the rewrite order is older-then-newer and that the fresh block waits. A design that lets fresh data win, or that rewrites only the failed block, would leave the newer block out of order on tape. The bench also sends a verdict for the newer block while the older one is still open. A design that treats it as an error, or that retires the wrong block, shows up in proto_err or in the next issued number. The bench drives exactly sixteen failures, looking for an off-by-one in the hard-error limit, and it checks the end-of-write repeat with one and with two blocks outstanding.

// File: rtl/tape_sched_pkg.sv
package tape_sched_pkg;
  // classification of one read-after-write verdict
  typedef enum logic [2:0] {
    VD_NONE   = 3'd0,
    VD_PASS   = 3'd1,
    VD_FAIL   = 3'd2,
    VD_IGNORE = 3'd3,
    VD_BAD    = 3'd4
  } verdict_e;

  // decision taken for one block slot
  typedef enum logic [2:0] {
    PICK_NONE   = 3'd0,
    PICK_OLDER  = 3'd1,
    PICK_NEWER  = 3'd2,
    PICK_FRESH  = 3'd3,
    PICK_REPEAT = 3'd4
  } pick_e;
endpackage

// File: rtl/tape_verdict_sort.sv
module tape_verdict_sort
  import tape_sched_pkg::*;
#(
  parameter int BLK_W = 16
) (
  input  logic             pass_i,
  input  logic             fail_i,
  input  logic [BLK_W-1:0] tag_i,
  input  logic             older_vld_i,
  input  logic [BLK_W-1:0] older_blk_i,
  input  logic             newer_vld_i,
  input  logic [BLK_W-1:0] newer_blk_i,
  output verdict_e         verdict_o
);
  logic hit_older, hit_newer, any_v, both_v;

  always_comb begin
    hit_older = older_vld_i && (tag_i == older_blk_i);
    hit_newer = newer_vld_i && (tag_i == newer_blk_i);
    any_v     = pass_i || fail_i;
    both_v    = pass_i && fail_i;
    if (!any_v)                    verdict_o = VD_NONE;
    else if (both_v)               verdict_o = VD_BAD;
    else if (hit_older && pass_i)  verdict_o = VD_PASS;
    else if (hit_older)            verdict_o = VD_FAIL;
    else if (hit_newer)            verdict_o = VD_IGNORE;
    else                           verdict_o = VD_BAD;
  end
endmodule

// File: rtl/tape_retry_ctr.sv
module tape_retry_ctr #(
  parameter int MAX_TRIES = 16,
  parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pass_i,
  input  logic             fail_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hard_o,
  output logic             exhaust_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_TRIES - 1);

  assign exhaust_o = fail_i && !hard_o && (cnt_o == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      hard_o <= 1'b0;
    end else begin
      if (pass_i)                cnt_o <= '0;
      else if (fail_i && !hard_o) cnt_o <= cnt_o + CNT_W'(1);
      if (exhaust_o) hard_o <= 1'b1;
    end
  end

  // R7
  hard_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    hard_o |=> hard_o);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= CNT_W'(MAX_TRIES));
  // R5
  pass_clears_chk: assert property (@(posedge clk) disable iff (rst)
    pass_i |=> (cnt_o == '0));
  // R4
  fail_counts_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_i && !pass_i && !hard_o) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/tape_rewrite_sched.sv
module tape_rewrite_sched
  import tape_sched_pkg::*;
#(
  parameter int BLK_W     = 16,
  parameter int MAX_TRIES = 16,
  parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_req,
  input  logic             data_rdy,
  input  logic [BLK_W-1:0] data_blk,
  input  logic             write_end,
  input  logic             crc_pass,
  input  logic             crc_fail,
  input  logic [BLK_W-1:0] crc_tag,
  output logic             issue_vld,
  output logic [BLK_W-1:0] issue_blk,
  output logic             issue_rewrite,
  output logic [CNT_W-1:0] retry_cnt,
  output logic             hard_err,
  output logic             proto_err
);
  // outstanding-block state
  logic             older_vld, newer_vld;
  logic [BLK_W-1:0] older_blk, newer_blk;
  logic             redo_older, redo_newer;

  verdict_e verdict;
  logic     exhaust;

  tape_verdict_sort #(.BLK_W(BLK_W)) i_sort (
    .pass_i      (crc_pass),
    .fail_i      (crc_fail),
    .tag_i       (crc_tag),
    .older_vld_i (older_vld),
    .older_blk_i (older_blk),
    .newer_vld_i (newer_vld),
    .newer_blk_i (newer_blk),
    .verdict_o   (verdict)
  );

  tape_retry_ctr #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) i_retry (
    .clk       (clk),
    .rst       (rst),
    .pass_i    (verdict == VD_PASS),
    .fail_i    (verdict == VD_FAIL),
    .cnt_o     (retry_cnt),
    .hard_o    (hard_err),
    .exhaust_o (exhaust)
  );

  // state after the verdict of this cycle, then after the slot decision
  logic             v_ovld, v_nvld, v_rdo, v_rdn;
  logic [BLK_W-1:0] v_oblk, v_nblk;
  logic             n_ovld, n_nvld, n_rdo, n_rdn;
  logic [BLK_W-1:0] n_oblk, n_nblk;
  pick_e            pick;
  logic [BLK_W-1:0] pick_blk;

  always_comb begin
    v_ovld = older_vld;  v_oblk = older_blk;
    v_nvld = newer_vld;  v_nblk = newer_blk;
    v_rdo  = redo_older; v_rdn  = redo_newer;
    if (verdict == VD_PASS) begin
      v_ovld = newer_vld;
      v_oblk = newer_blk;
      v_nvld = 1'b0;
      v_rdo  = redo_newer;
      v_rdn  = 1'b0;
    end else if (verdict == VD_FAIL && !exhaust) begin
      v_rdo  = 1'b1;
      v_rdn  = 1'b0;
    end

    n_ovld = v_ovld; n_oblk = v_oblk;
    n_nvld = v_nvld; n_nblk = v_nblk;
    n_rdo  = v_rdo;  n_rdn  = v_rdn;
    pick     = PICK_NONE;
    pick_blk = '0;

    if (slot_req && !hard_err && !exhaust) begin
      if (v_rdo) begin
        pick     = PICK_OLDER;
        pick_blk = v_oblk;
        n_rdo    = 1'b0;
        n_rdn    = v_nvld;
      end else if (v_rdn) begin
        pick     = PICK_NEWER;
        pick_blk = v_nblk;
        n_rdn    = 1'b0;
      end else if (data_rdy && !v_nvld) begin
        pick     = PICK_FRESH;
        pick_blk = data_blk;
        if (v_ovld) begin
          n_nvld = 1'b1;
          n_nblk = data_blk;
        end else begin
          n_ovld = 1'b1;
          n_oblk = data_blk;
        end
      end else if (write_end && !data_rdy) begin
        if (v_nvld) begin
          pick     = PICK_REPEAT;
          pick_blk = v_nblk;
        end else if (v_ovld) begin
          pick     = PICK_REPEAT;
          pick_blk = v_oblk;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      older_vld     <= 1'b0;
      newer_vld     <= 1'b0;
      older_blk     <= '0;
      newer_blk     <= '0;
      redo_older    <= 1'b0;
      redo_newer    <= 1'b0;
      issue_vld     <= 1'b0;
      issue_blk     <= '0;
      issue_rewrite <= 1'b0;
      proto_err     <= 1'b0;
    end else begin
      older_vld     <= n_ovld;
      newer_vld     <= n_nvld;
      older_blk     <= n_oblk;
      newer_blk     <= n_nblk;
      redo_older    <= n_rdo;
      redo_newer    <= n_rdn;
      issue_vld     <= (pick != PICK_NONE);
      issue_blk     <= pick_blk;
      issue_rewrite <= (pick != PICK_NONE) && (pick != PICK_FRESH);
      proto_err     <= (verdict == VD_BAD);
    end
  end

  // R7
  hard_blocks_issue_chk: assert property (@(posedge clk) disable iff (rst)
    hard_err |-> !issue_vld);
  // R2
  fresh_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && !issue_rewrite) |-> $past(data_rdy && slot_req));
  // R8
  proto_needs_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(crc_pass || crc_fail));
  // R3
  two_open_limit_chk: assert property (@(posedge clk) disable iff (rst)
    !(newer_vld && !older_vld));
  // R2
  issue_needs_slot_chk: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> $past(slot_req));
endmodule

// File: tb/test_tape_rewrite_sched.sv
module test_tape_rewrite_sched;
  localparam int BW = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_req = 0, data_rdy = 0, write_end = 0;
  logic crc_pass = 0, crc_fail = 0;
  logic [BW-1:0] data_blk = '0, crc_tag = '0;
  logic issue_vld, issue_rewrite, hard_err, proto_err;
  logic [BW-1:0] issue_blk;
  logic [CW-1:0] retry_cnt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tape_rewrite_sched #(.BLK_W(BW), .MAX_TRIES(16)) i_tape_rewrite_sched (
    .clk(clk), .rst(rst), .slot_req(slot_req), .data_rdy(data_rdy),
    .data_blk(data_blk), .write_end(write_end), .crc_pass(crc_pass),
    .crc_fail(crc_fail), .crc_tag(crc_tag), .issue_vld(issue_vld),
    .issue_blk(issue_blk), .issue_rewrite(issue_rewrite),
    .retry_cnt(retry_cnt), .hard_err(hard_err), .proto_err(proto_err));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_issue(input string req, input int v, input int b, input int rw);
    chk({req, " vld"}, int'(issue_vld), v);
    if (v != 0) begin
      chk({req, " blk"}, int'(issue_blk), b);
      chk({req, " rewrite"}, int'(issue_rewrite), rw);
    end
  endtask

  // one slot request; outputs are checked at the following negedge
  task automatic slot(input logic rdy, input int blk, input logic fin);
    slot_req = 1; data_rdy = rdy; data_blk = BW'(blk); write_end = fin;
    @(negedge clk);
    slot_req = 0; data_rdy = 0; write_end = 0;
  endtask

  task automatic verdict(input logic p, input logic f, input int tag);
    crc_pass = p; crc_fail = f; crc_tag = BW'(tag);
    @(negedge clk);
    crc_pass = 0; crc_fail = 0;
  endtask

  task automatic do_reset;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 issue_vld", int'(issue_vld), 0);
    chk("R1 hard_err", int'(hard_err), 0);
    chk("R1 proto_err", int'(proto_err), 0);
    chk("R1 retry_cnt", int'(retry_cnt), 0);
    slot(0, 0, 1);  // nothing outstanding: repeat request yields nothing
    chk_issue("R1 nothing outstanding", 0, 0, 0);
  endtask

  task automatic t_clean_stream;
    do_reset();
    slot(1, 5, 0);  chk_issue("R2 first fresh", 1, 5, 0);
    slot(1, 6, 0);  chk_issue("R2 second fresh", 1, 6, 0);
    verdict(1, 0, 5); chk("R5 retry after pass", int'(retry_cnt), 0);
    slot(1, 7, 0);  chk_issue("R5 fresh after retire", 1, 7, 0);
    chk("R2 no proto", int'(proto_err), 0);
  endtask

  task automatic t_interleave;
    do_reset();
    slot(1, 10, 0); chk_issue("R2 blk10", 1, 10, 0);
    slot(1, 11, 0); chk_issue("R2 blk11", 1, 11, 0);
    slot(1, 12, 0); chk_issue("R3 two outstanding", 0, 0, 0);
    verdict(0, 1, 10); chk("R4 retry one", int'(retry_cnt), 1);
    slot(1, 12, 0); chk_issue("R4 R10 older rewrite first", 1, 10, 1);
    slot(1, 12, 0); chk_issue("R4 R10 newer rewrite next", 1, 11, 1);
    slot(1, 12, 0); chk_issue("R3 still waiting", 0, 0, 0);
    verdict(1, 0, 12); chk("R8 unknown tag proto", int'(proto_err), 1);
    verdict(1, 0, 11);
    chk("R9 newer tag no proto", int'(proto_err), 0);
    chk("R9 retry kept", int'(retry_cnt), 1);
    verdict(1, 0, 10); chk("R5 retry cleared", int'(retry_cnt), 0);
    slot(1, 12, 0); chk_issue("R5 fresh after pass", 1, 12, 0);
    slot(0, 0, 1);  chk_issue("R6 repeat newest", 1, 12, 1);
    verdict(1, 0, 11);
    verdict(1, 0, 12);
    slot(0, 0, 1);  chk_issue("R6 all verified", 0, 0, 0);
  endtask

  task automatic t_tail_single;
    do_reset();
    slot(1, 40, 0); chk_issue("R2 blk40", 1, 40, 0);
    slot(0, 0, 1);  chk_issue("R6 repeat last", 1, 40, 1);
    verdict(0, 1, 40); chk("R4 tail fail count", int'(retry_cnt), 1);
    slot(0, 0, 1);  chk_issue("R4 tail rewrite", 1, 40, 1);
    verdict(1, 0, 40);
    slot(0, 0, 1);  chk_issue("R6 done", 0, 0, 0);
  endtask

  task automatic t_proto;
    do_reset();
    slot(1, 30, 0); chk_issue("R2 blk30", 1, 30, 0);
    verdict(0, 1, 99);
    chk("R8 proto pulse", int'(proto_err), 1);
    chk("R8 retry unchanged", int'(retry_cnt), 0);
    @(negedge clk);
    chk("R8 proto one cycle", int'(proto_err), 0);
    verdict(1, 1, 30);
    chk("R8 both pulses proto", int'(proto_err), 1);
    chk("R8 both retry unchanged", int'(retry_cnt), 0);
    slot(0, 0, 1); chk_issue("R8 state kept", 1, 30, 1);
  endtask

  task automatic t_hard;
    do_reset();
    slot(1, 20, 0); chk_issue("R2 blk20", 1, 20, 0);
    for (int i = 0; i < 15; i++) verdict(0, 1, 20);
    chk("R7 fifteen fails", int'(retry_cnt), 15);
    chk("R7 not yet hard", int'(hard_err), 0);
    verdict(0, 1, 20);
    chk("R7 sixteenth hard", int'(hard_err), 1);
    chk("R7 count at limit", int'(retry_cnt), 16);
    slot(1, 21, 0); chk_issue("R7 blocked", 0, 0, 0);
    @(negedge clk);
    chk("R7 sticky", int'(hard_err), 1);
    do_reset();
    chk("R1 hard cleared", int'(hard_err), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_clean_stream();
    t_interleave();
    t_tail_single();
    t_proto();
    t_hard();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule